// File: doc/BRIEF.md
# Two-Channel Programmable Interval Timer

This block is a byte-wide, register-mapped interval timer with two independent down-counting channels, numbered 0 and 2. Both share one control port, and each has its own data port. Software first writes a control word that names a channel and its operating mode. It then loads a 16-bit count into that channel's data port as two byte writes: the low byte first, then the high byte.

Once the high byte arrives, the channel counts down once per reference tick. A per-channel prescaler produces the tick enable from the system clock. In one-shot mode the channel raises a terminal-count flag in its status byte and halts. In every other mode it reloads the programmed count and runs again. The block rejects any access it does not support, such as a wrong width, an unknown port, a read-back select or a byte-access field other than low-then-high. It flags these with a one-cycle error pulse, and a rejected access changes no state.

The parameter `CLKS_PER_TICK` sets how many system clocks make one reference tick. With a 125 MHz system clock, the default of 105 approximates the 1.19318 MHz timing reference. A count of N therefore spans N x 1/1,193,180 s.

Top module: `pit_interval_timer`

## Requirements
- R1: In a control word written to port 3, bits 7:6 pick the channel: 0 selects channel 0 and 2 selects channel 2. The value 1 or 3 (read-back) is rejected with an error pulse and changes no channel's mode.
- R2: Control word bits 5:4 must be 2'b11. Any other value is rejected with an error pulse and leaves the mode unchanged.
- R3: The mode comes from control word bits 3:1. In mode 0, the channel pulses `expire_o` exactly count x CLKS_PER_TICK clocks after the high-byte load. It then sets status bit 5 (a status read returns 0x20) and stops with no further pulses.
- R4: In any nonzero mode, the channel pulses `expire_o` every count x CLKS_PER_TICK clocks. It reloads the count each time and its status stays 0x00.
- R5: The data port of channel k is port k (0 or 2). The first write holds the low byte and starts nothing. The second write holds the high byte and starts the count. After that, the next write is again a low byte.
- R6: Loading a new count clears the channel's status to 0x00.
- R7: A loaded count of 0 behaves as 65536.
- R8: An access with `acc_size` other than 0 (single byte) is rejected with an error pulse and has no effect on any channel.
- R9: A read of port 0 or port 2 returns that channel's status on `rdata` in the cycle after the access. After reset, every status is 0x00 and `err_o` and `expire_o` are low.
- R10: `err_o` is high only in the cycle after a rejected access. A read of port 1 or port 3, or a write to port 1, is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Port select: 0 ch0 data, 2 ch2 data, 3 control |
| acc_size | input | 2 | Access width code, 0 = single byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Status byte of the last accepted read |
| err_o | output | 1 | One-cycle pulse after a rejected access |
| expire_o | output | NUM_CH | Per-channel terminal-count pulse (bit 0 ch0, bit 1 ch2) |

## Verification
Several properties are checked on every cycle. The byte flag must clear after a high-byte load, and a load must clear status and start the channel. A one-shot expiry must leave the channel halted with its flag set, while a periodic expiry must leave it running. The counter must hold between ticks, and every error pulse must trace back to an access. Only the bench scenarios can show the exact spacing of expiries in clocks and the 65536 reading of a zero count. They also show that rejected control words and wrong-width writes leave the mode and the byte pairing untouched, because that appears only in later pulse timing.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = 2 * BYTE_W;

   localparam logic [1:0] PORT_CTL   = 2'd3;
   localparam logic [1:0] SIZE_BYTE  = 2'd0;
   localparam logic [1:0] ACC_LO_HI  = 2'b11;

   localparam int SEL_LSB  = 6;
   localparam int ACC_LSB  = 4;
   localparam int MODE_LSB = 1;
   localparam int MODE_W   = 3;

   localparam logic [MODE_W-1:0] MODE_ONESHOT = '0;
   localparam int TC_BIT = 5;
endpackage

// File: rtl/pit_bus_decode.sv
`timescale 1ns/1ps
module pit_bus_decode
   import pit_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [1:0]        acc_size,
   input  logic [3:0]        ctl_hi,
   output logic [NUM_CH-1:0] ctl_we,
   output logic [NUM_CH-1:0] dat_we,
   output logic [NUM_CH-1:0] rd_sel,
   output logic              reject
);
   logic byte_ok;
   logic ctl_ok;
   logic [1:0] sel_f;
   logic [1:0] acc_f;

   assign byte_ok = (acc_size == SIZE_BYTE);
   assign sel_f   = ctl_hi[SEL_LSB-4 +: 2];
   assign acc_f   = ctl_hi[ACC_LSB-4 +: 2];
   assign ctl_ok  = wr_en && byte_ok && (addr == PORT_CTL) && (acc_f == ACC_LO_HI);

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      localparam logic [1:0] CH_CODE = 2'(2 * k);
      assign ctl_we[k] = ctl_ok && (sel_f == CH_CODE);
      assign dat_we[k] = wr_en && byte_ok && (addr == CH_CODE);
      assign rd_sel[k] = rd_en && !wr_en && byte_ok && (addr == CH_CODE);
   end

   assign reject = (wr_en || rd_en) && !((|ctl_we) || (|dat_we) || (|rd_sel));
endmodule

// File: rtl/pit_prescale.sv
`timescale 1ns/1ps
module pit_prescale #(
   parameter int DIV = 105
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("pit_prescale: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_direct
      assign tick = run & ~clear;
   end else begin : g_count
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      assign tick = run && !clear && (pre_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pre_q <= '0;
         else if (clear)
            pre_q <= '0;
         else if (run)
            pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
      end
   end
endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
   import pit_pkg::*;
#(
   parameter int DIV = 105
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              dat_we,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] status,
   output logic              expire
);
   logic [MODE_W-1:0] mode_q;
   logic [BYTE_W-1:0] lo_q;
   logic              have_lo_q;
   logic [CNT_W-1:0]  reload_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              run_q;
   logic              tc_q;
   logic              expire_q;
   logic              load;
   logic              tick;

   assign load = dat_we && have_lo_q;

   pit_prescale #(.DIV(DIV)) u_prescale (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (load),
      .run   (run_q),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= MODE_ONESHOT;
      else if (ctl_we)
         mode_q <= wdata[MODE_LSB +: MODE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q      <= '0;
         have_lo_q <= 1'b0;
         reload_q  <= '0;
         cnt_q     <= '0;
         run_q     <= 1'b0;
         tc_q      <= 1'b0;
         expire_q  <= 1'b0;
      end else begin
         expire_q <= 1'b0;
         if (dat_we) begin
            if (!have_lo_q) begin
               lo_q      <= wdata;
               have_lo_q <= 1'b1;
            end else begin
               have_lo_q <= 1'b0;
               reload_q  <= {wdata, lo_q};
               cnt_q     <= {wdata, lo_q};
               run_q     <= 1'b1;
               tc_q      <= 1'b0;
            end
         end else if (tick) begin
            if (cnt_q == CNT_W'(1)) begin
               expire_q <= 1'b1;
               if (mode_q == MODE_ONESHOT) begin
                  run_q <= 1'b0;
                  tc_q  <= 1'b1;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= reload_q;
               end
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign status = BYTE_W'(tc_q) << TC_BIT;
   assign expire = expire_q;

   a_r5_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && have_lo_q) |=> !have_lo_q);

   a_r6_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && have_lo_q) |=> (status == '0) && run_q);

   a_r3_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_q && $past(mode_q) == MODE_ONESHOT && !$past(dat_we)) |-> (!run_q && status[TC_BIT]));

   a_r4_periodic_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_q && $past(mode_q) != MODE_ONESHOT && !$past(dat_we)) |-> (run_q && status == '0));

   a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !dat_we) |=> $stable(cnt_q));
endmodule

// File: rtl/pit_interval_timer.sv
`timescale 1ns/1ps
module pit_interval_timer
   import pit_pkg::*;
#(
   parameter int CLKS_PER_TICK = 105,
   parameter int NUM_CH        = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [1:0]        acc_size,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              err_o,
   output logic [NUM_CH-1:0] expire_o
);
   if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
      $error("pit_interval_timer: NUM_CH must be 1 or 2");
   end
   if (CLKS_PER_TICK < 1) begin : g_bad_tick
      $error("pit_interval_timer: CLKS_PER_TICK must be positive");
   end

   logic [NUM_CH-1:0] ctl_we;
   logic [NUM_CH-1:0] dat_we;
   logic [NUM_CH-1:0] rd_sel;
   logic              reject;
   logic [BYTE_W-1:0] stat [NUM_CH];
   logic [BYTE_W-1:0] rd_mux;
   logic [BYTE_W-1:0] rdata_q;
   logic              err_q;

   pit_bus_decode #(.NUM_CH(NUM_CH)) u_decode (
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .acc_size (acc_size),
      .ctl_hi   (wdata[7:4]),
      .ctl_we   (ctl_we),
      .dat_we   (dat_we),
      .rd_sel   (rd_sel),
      .reject   (reject)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
      pit_channel #(.DIV(CLKS_PER_TICK)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .ctl_we (ctl_we[k]),
         .dat_we (dat_we[k]),
         .wdata  (wdata),
         .status (stat[k]),
         .expire (expire_o[k])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < NUM_CH; k++)
         if (rd_sel[k]) rd_mux = rd_mux | stat[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= reject;
         if (|rd_sel) rdata_q <= rd_mux;
      end
   end

   assign rdata = rdata_q;
   assign err_o = err_q;

   a_r10_err_traces_access: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(wr_en || rd_en));

   a_r8_one_port_per_access: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl_we != '0, dat_we != '0, rd_sel != '0}));
endmodule

// File: tb/test_pit_interval_timer.sv
`timescale 1ns/1ps
module test_pit_interval_timer;
   localparam int DIV = 2;
   localparam int PER = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [1:0] addr = '0;
   logic [1:0] acc_size = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       err_o;
   logic [1:0] expire_o;

   int checks = 0;
   int errors = 0;
   longint q [2][$];
   bit watch [2] = '{1'b1, 1'b1};
   logic last_err;
   logic [7:0] rd_val;
   longint t_load;

   pit_interval_timer #(.CLKS_PER_TICK(DIV), .NUM_CH(2)) i_pit_interval_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .acc_size(acc_size), .wdata(wdata), .rdata(rdata), .err_o(err_o),
      .expire_o(expire_o)
   );

   always #(PER/2) clk = ~clk;

   task automatic check(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [1:0] sz);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d; acc_size = sz;
      @(posedge clk);
      t_load = $time;
      @(negedge clk);
      last_err = err_o;
      wr_en = 1'b0; acc_size = '0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [1:0] sz);
      @(negedge clk);
      rd_en = 1'b1; addr = a; acc_size = sz;
      @(posedge clk);
      @(negedge clk);
      last_err = err_o;
      rd_val = rdata;
      rd_en = 1'b0; acc_size = '0;
   endtask

   // driver: load a count and push the expected expiry times
   task automatic load(input int ch, input logic [7:0] lo, input logic [7:0] hi,
                       input int pulses, input string req);
      longint cnt;
      wr(2'(2*ch), lo, 2'd0);
      check({req, " low-byte err"}, last_err, 0);
      wr(2'(2*ch), hi, 2'd0);
      check({req, " high-byte err"}, last_err, 0);
      cnt = ({hi, lo} == 16'd0) ? 65536 : longint'({hi, lo});
      for (int j = 1; j <= pulses; j++)
         q[ch].push_back(t_load + j * cnt * DIV * PER + PER/2);
   endtask

   task automatic wait_empty(input int ch);
      while (q[ch].size() != 0) @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: each expiry pulse must match the front of the queue
   always @(negedge clk) begin
      for (int ch = 0; ch < 2; ch++) begin
         if (rst_n && expire_o[ch] && watch[ch]) begin
            if (q[ch].size() == 0) begin
               checks++; errors++;
               $display("FAIL R3/R4/R5 ch%0d unexpected expiry: actual %0t expected none", 2*ch, $time);
            end else begin
               check($sformatf("R3/R4 ch%0d expiry time", 2*ch), $time, q[ch].pop_front());
            end
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R9 reset state
      check("R9 reset err", err_o, 0);
      check("R9 reset expire", expire_o, 0);
      rd(2'd0, 2'd0); check("R9 ch0 reset status", rd_val, 8'h00);
      rd(2'd2, 2'd0); check("R9 ch2 reset status", rd_val, 8'h00);

      // R3 one-shot on ch0, R5 low byte alone starts nothing
      wr(2'd3, 8'h30, 2'd0); check("R1 ctl ch0 err", last_err, 0);
      wr(2'd0, 8'd5, 2'd0);
      idle(40);
      wr(2'd0, 8'd0, 2'd0);
      q[0].push_back(t_load + 5 * DIV * PER + PER/2);
      wait_empty(0);
      rd(2'd0, 2'd0); check("R3 one-shot status", rd_val, 8'h20);
      idle(100);

      // R6 reload clears status, R5 flag cleared so this pair is a fresh load
      load(0, 8'd3, 8'd0, 1, "R5");
      rd(2'd0, 2'd0); check("R6 status cleared on load", rd_val, 8'h00);
      wait_empty(0);
      rd(2'd0, 2'd0); check("R3 status after second run", rd_val, 8'h20);

      // R4 periodic on ch2, mode 2
      wr(2'd3, 8'hB4, 2'd0); check("R1 ctl ch2 err", last_err, 0);
      load(1, 8'd6, 8'd0, 3, "R4");
      wait_empty(1);
      rd(2'd2, 2'd0); check("R4 periodic status", rd_val, 8'h00);
      watch[1] = 1'b0;

      // R1 invalid selects, R2 invalid access field: ch0 must stay one-shot
      wr(2'd3, 8'h74, 2'd0); check("R1 select 1 rejected", last_err, 1);
      wr(2'd3, 8'hF4, 2'd0); check("R1 read-back rejected", last_err, 1);
      wr(2'd3, 8'h14, 2'd0); check("R2 access field rejected", last_err, 1);
      idle(1);
      check("R10 err one cycle", err_o, 0);
      load(0, 8'd2, 8'd0, 1, "R2");
      wait_empty(0);
      idle(40);
      rd(2'd0, 2'd0); check("R2 mode unchanged, one-shot status", rd_val, 8'h20);

      // R8 non-byte accesses have no effect
      wr(2'd0, 8'd4, 2'd1); check("R8 wide write rejected", last_err, 1);
      rd(2'd0, 2'd2); check("R8 wide read rejected", last_err, 1);
      load(0, 8'd2, 8'd0, 1, "R8");
      wait_empty(0);

      // R10 bad ports
      rd(2'd3, 2'd0); check("R10 control read rejected", last_err, 1);
      wr(2'd1, 8'h00, 2'd0); check("R10 port 1 write rejected", last_err, 1);
      rd(2'd0, 2'd0); check("R10 good read no err", last_err, 0);

      // R7 zero count means 65536
      load(0, 8'd0, 8'd0, 1, "R7");
      wait_empty(0);
      rd(2'd0, 2'd0); check("R7 status after 65536 ticks", rd_val, 8'h20);

      finish_run();
   end
endmodule